// File: doc/BRIEF.md
# Infrared Pulse Line Codec

This block sits between a UART engine and an infrared transceiver. On the transmit side it takes the engine's NRZ serial stream, which idles high, and turns it into return-to-zero light pulses. Every zero bit becomes one short high pulse at the start of its bit period. One bits and idle time leave the infrared output dark. On the receive side it watches the raw optical input and stretches each detected pulse into a zero bit that lasts one whole bit period. The engine's receiver can then sample the result as ordinary NRZ data.

Bit timing comes from an oversample tick that pulses for one clock, 16 times per bit. The pulse width has two settings. By default it is three oversample ticks. In fixed mode it is a power-of-two number of peripheral clocks, chosen by a 3-bit code, so the width stays the same at any baud rate. The receive input can be inverted before it is decoded. The codec works only when the shared serial-mode code selects infrared operation. In every other mode both outputs rest at their idle levels.

Top module: `irda_codec`

## Requirements
- R1: Out of reset, `ir_tx` is 0 and `nrz_rx` is 1.
- R2: A bit period starts at an `os_tick` when the encoder is idle, and again every 16 ticks after that while bits keep coming. A zero on `nrz_tx` at that tick raises `ir_tx` on the same clock edge. A one bit, or an idle line, produces no pulse.
- R3: When `fixed_en` is 0, each pulse lasts exactly 3 oversample ticks.
- R4: When `fixed_en` is 1, each pulse lasts 2^(code+1) clock cycles, where code is the value of `width_code` (0 gives 2 cycles, 7 gives 256 cycles).
- R5: A pulse never outlasts its bit period. A width longer than 16 ticks is cut off at the next bit boundary.
- R6: The codec is active only when `mode_sel` equals 2 (the infrared mode). Codes 0, 1, 3, 4 and 5 are the other modes: plain UART, modem, smart card, synchronous and RS-485. In any of them `ir_tx` stays 0 and `nrz_rx` stays 1, whatever the inputs do.
- R7: A rising edge on the decoded infrared input passes through a 2-stage synchronizer and an edge detector. Three clock edges after the raw input is first sampled high, `nrz_rx` goes low. It stays low until the 16th `os_tick` that follows, then returns high.
- R8: When `rx_invert` is 1, the raw infrared input is inverted before decoding. A low-going pulse on a line that idles high then decodes the same way a high pulse does when `rx_invert` is 0.
- R9: A new pulse edge that arrives while `nrz_rx` is already held low restarts the 16-tick hold.
- R10: Back-to-back zero bits each produce a pulse of their own, separated by a low gap, as long as the width is shorter than the bit period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | Oversample strobe, one clock wide, 16 per bit |
| nrz_tx | input | 1 | NRZ transmit data from the UART engine |
| ir_rx_raw | input | 1 | Raw infrared receive input |
| mode_sel | input | 3 | Serial mode code; 2 selects infrared |
| rx_invert | input | 1 | Invert the receive input before decoding |
| fixed_en | input | 1 | Use a fixed pulse width in clock cycles |
| width_code | input | 3 | Fixed-width code n, width 2^(n+1) clocks |
| ir_tx | output | 1 | Infrared transmit pulse output |
| nrz_rx | output | 1 | Recovered NRZ receive data |

## Verification
The hardest case to reach from the ports is the restart of the receive hold: a second pulse edge has to land while `nrz_rx` is still low from the first. The bench makes this happen by driving every clock, tick and input from one stepping task. Because of that, the tick phase at each pulse edge is known exactly. The second pulse is placed 40 clocks after the first, and the bench checks that the total low time equals the exact cycle count from that second edge to its own 16th tick. The cut-off of over-long fixed pulses is reached the same way, using code 7 against a 64-clock bit period.

// File: rtl/irda_codec.sv
module irda_codec #(
  parameter int                OVS        = 16,
  parameter int                NORM_TICKS = 3,
  parameter int                CODE_W     = 3,
  parameter int                MODE_W     = 3,
  parameter logic [MODE_W-1:0] MODE_IR    = 3'd2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_tick,
  input  logic              nrz_tx,
  input  logic              ir_rx_raw,
  input  logic [MODE_W-1:0] mode_sel,
  input  logic              rx_invert,
  input  logic              fixed_en,
  input  logic [CODE_W-1:0] width_code,
  output logic              ir_tx,
  output logic              nrz_rx
);
  localparam int PH_W = $clog2(OVS);
  localparam int NT_W = $clog2(NORM_TICKS) + 1;
  localparam int PC_W = (1 << CODE_W) + 1;

  logic              irda;
  logic              tx_run, tx_pulse, tx_bound, tx_start;
  logic [PH_W-1:0]   tx_ph;
  logic [NT_W-1:0]   tx_ntk;
  logic [PC_W-1:0]   tx_pcnt, fixed_w;
  logic              rx_in, rx_s1, rx_s2, rx_s3, rx_edge, rx_hold;
  logic [PH_W-1:0]   rx_cnt;

  assign irda     = (mode_sel == MODE_IR);
  assign tx_bound = os_tick && (!tx_run || tx_ph == PH_W'(OVS - 1));
  assign tx_start = irda && tx_bound && !nrz_tx;
  assign fixed_w  = PC_W'(1) << ({1'b0, width_code} + (CODE_W + 1)'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_run   <= 1'b0;
      tx_ph    <= '0;
      tx_pulse <= 1'b0;
      tx_ntk   <= '0;
      tx_pcnt  <= '0;
    end else if (!irda) begin
      tx_run   <= 1'b0;
      tx_ph    <= '0;
      tx_pulse <= 1'b0;
      tx_ntk   <= '0;
      tx_pcnt  <= '0;
    end else begin
      if (tx_bound) begin
        tx_run <= !nrz_tx;
        tx_ph  <= '0;
      end else if (os_tick && tx_run) begin
        tx_ph <= tx_ph + PH_W'(1);
      end

      if (tx_start) begin
        tx_pulse <= 1'b1;
        tx_ntk   <= '0;
        tx_pcnt  <= '0;
      end else if (tx_bound) begin
        tx_pulse <= 1'b0;
      end else if (tx_pulse) begin
        if (fixed_en) begin
          tx_pcnt <= tx_pcnt + PC_W'(1);
          if (tx_pcnt == fixed_w - PC_W'(1)) tx_pulse <= 1'b0;
        end else if (os_tick) begin
          tx_ntk <= tx_ntk + NT_W'(1);
          if (tx_ntk == NT_W'(NORM_TICKS - 1)) tx_pulse <= 1'b0;
        end
      end
    end
  end

  assign ir_tx = tx_pulse;

  assign rx_in   = ir_rx_raw ^ rx_invert;
  assign rx_edge = rx_s2 && !rx_s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_s1 <= 1'b0;
      rx_s2 <= 1'b0;
      rx_s3 <= 1'b0;
    end else begin
      rx_s1 <= rx_in;
      rx_s2 <= rx_s1;
      rx_s3 <= rx_s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_hold <= 1'b0;
      rx_cnt  <= '0;
    end else if (!irda) begin
      rx_hold <= 1'b0;
      rx_cnt  <= '0;
    end else if (rx_edge) begin
      rx_hold <= 1'b1;
      rx_cnt  <= '0;
    end else if (rx_hold && os_tick) begin
      if (rx_cnt == PH_W'(OVS - 1)) rx_hold <= 1'b0;
      else rx_cnt <= rx_cnt + PH_W'(1);
    end
  end

  assign nrz_rx = !rx_hold;
endmodule

module irda_codec_chk #(
  parameter int                MODE_W  = 3,
  parameter logic [MODE_W-1:0] MODE_IR = 3'd2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              os_tick,
  input logic              nrz_tx,
  input logic              ir_rx_raw,
  input logic              rx_invert,
  input logic [MODE_W-1:0] mode_sel,
  input logic              ir_tx,
  input logic              nrz_rx
);
  AST_TX_QUIET_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel != MODE_IR) |=> !ir_tx);                                   // R6
  AST_RX_QUIET_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel != MODE_IR) |=> nrz_rx);                                   // R6
  AST_TX_START_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ir_tx) |-> ($past(os_tick) && !$past(nrz_tx)));                // R2
  AST_RX_FALL_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nrz_rx) |-> $past(ir_rx_raw ^ rx_invert, 3));                  // R7
  AST_TX_MODE_ON: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ir_tx) |-> $past(mode_sel == MODE_IR));                        // R6
endmodule

bind irda_codec irda_codec_chk #(.MODE_W(MODE_W), .MODE_IR(MODE_IR)) u_chk (
  .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .nrz_tx(nrz_tx),
  .ir_rx_raw(ir_rx_raw), .rx_invert(rx_invert), .mode_sel(mode_sel),
  .ir_tx(ir_tx), .nrz_rx(nrz_rx)
);

// File: tb/sim_irda_codec.sv
module sim_irda_codec;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 4;
  localparam int OVS        = 16;
  localparam int BITLEN     = OVS * DIV;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       os_tick = 1'b0;
  logic       nrz_tx = 1'b1;
  logic       ir_rx_raw = 1'b0;
  logic [2:0] mode_sel = 3'd2;
  logic       rx_invert = 1'b0;
  logic       fixed_en = 1'b0;
  logic [2:0] width_code = 3'd0;
  logic       ir_tx, nrz_rx;

  int n_chk = 0, n_bad = 0;
  int ph = 0, idx = 0, hi = 0, rises = 0, lo = 0, first_rise = -1, first_lo = -1;
  logic last_ir = 1'b0;

  irda_codec u0 (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .nrz_tx(nrz_tx),
    .ir_rx_raw(ir_rx_raw), .mode_sel(mode_sel), .rx_invert(rx_invert),
    .fixed_en(fixed_en), .width_code(width_code), .ir_tx(ir_tx), .nrz_rx(nrz_rx)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (ir_tx) hi++;
    if (ir_tx && !last_ir) begin
      rises++;
      if (first_rise < 0) first_rise = idx;
    end
    if (!nrz_rx) begin
      lo++;
      if (first_lo < 0) first_lo = idx;
    end
    last_ir = ir_tx;
    idx++;
    os_tick = (ph == 0);
    ph = (ph + 1) % DIV;
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic align();
    while (ph != 0) step();
  endtask

  task automatic clear_meas();
    idx = 0; hi = 0; rises = 0; lo = 0; first_rise = -1; first_lo = -1;
  endtask

  task automatic send_bit(logic b);
    nrz_tx = b;
    steps(BITLEN);
  endtask

  task automatic rx_pulse(int len, logic active);
    ir_rx_raw = active;
    steps(len);
    ir_rx_raw = !active;
  endtask

  task automatic t_reset();
    step();
    check("R1 ir_tx after reset", int'(ir_tx), 0);
    check("R1 nrz_rx after reset", int'(nrz_rx), 1);
  endtask

  task automatic t_single_zero();
    fixed_en = 0; align(); clear_meas();
    send_bit(0); send_bit(1); send_bit(1);
    check("R2 pulse starts one clock after first tick", first_rise, 1);
    check("R3 normal width 3 ticks", hi, 3 * DIV);
    check("R2 one pulse for one zero bit", rises, 1);
  endtask

  task automatic t_ones();
    align(); clear_meas();
    send_bit(1); send_bit(1); steps(BITLEN);
    check("R2 no pulse for ones and idle", hi, 0);
  endtask

  task automatic t_seq();
    fixed_en = 0; align(); clear_meas();
    send_bit(0); send_bit(0); send_bit(1); send_bit(0); send_bit(1); send_bit(1);
    check("R10 separate pulses for adjacent zeros", rises, 3);
    check("R10 total high time", hi, 3 * 3 * DIV);
  endtask

  task automatic t_fixed(int code, int exp, string req);
    fixed_en = 1; width_code = 3'(code); align(); clear_meas();
    send_bit(0); send_bit(1); send_bit(1);
    check(req, hi, exp);
    check(req, rises, 1);
    fixed_en = 0;
  endtask

  task automatic t_mode(int code);
    mode_sel = 3'(code); align(); clear_meas();
    send_bit(0); send_bit(0); send_bit(1);
    rx_pulse(3, 1); steps(120);
    check("R6 ir_tx quiet outside infrared mode", hi, 0);
    check("R6 nrz_rx high outside infrared mode", lo, 0);
    mode_sel = 3'd2;
    steps(8);
  endtask

  task automatic t_rx();
    align(); clear_meas();
    rx_pulse(3, 1); steps(130);
    check("R7 low after three edges", first_lo, 2);
    check("R7 held low for 16 ticks", lo, 63);
    check("R7 returns high", int'(nrz_rx), 1);
  endtask

  task automatic t_retrig();
    align(); clear_meas();
    rx_pulse(3, 1); steps(37);
    rx_pulse(3, 1); steps(150);
    check("R9 hold restarted by second edge", lo, 103);
  endtask

  task automatic t_invert();
    rx_invert = 1; ir_rx_raw = 1;
    steps(8); align(); clear_meas();
    steps(60);
    check("R8 idle-high line decodes as idle", lo, 0);
    align(); clear_meas();
    rx_pulse(3, 0); steps(130);
    check("R8 low-going pulse decoded", lo, 63);
    check("R8 first low", first_lo, 2);
    rx_invert = 0; ir_rx_raw = 0;
    steps(8);
  endtask

  initial begin
    steps(3);
    rst_n = 1'b1;
    t_reset();
    steps(5);
    t_single_zero();
    t_ones();
    t_seq();
    t_fixed(0, 2, "R4 fixed code 0 width");
    t_fixed(4, 32, "R4 fixed code 4 width");
    t_fixed(7, BITLEN, "R5 fixed code 7 clipped to bit");
    t_mode(0);
    t_mode(4);
    t_rx();
    t_retrig();
    t_invert();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule